// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst on a synchronous burst memory. A burst opens when either of two active-low start strobes is seen low at a rising clock edge. One strobe serves a processor and the other a cache controller. At that edge the block captures the full external address. The two lowest bits of the captured address become the starting point of the burst.

After the start, each rising edge with the active-low step input low moves the burst on by one beat. The order of the low address bits depends on a static order-select input. With the input low, the low bits count upward by one and wrap at four. With the input high, the low bits are the starting value XORed with the beat number. The upper address bits keep their captured value for the whole burst. The block also outputs the current beat number, so a memory controller can tell where it is in the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after it rises until the first start, mem_addr and beat_pos are zero.
- R2: When start_cpu_n is sampled low at a rising edge, mem_addr equals the sampled req_addr after that edge, and beat_pos is 0.
- R3: When start_cache_n is sampled low at a rising edge, mem_addr equals the sampled req_addr after that edge, and beat_pos is 0.
- R4: When no strobe is low and step_n is sampled low, beat_pos increases by one, modulo 4. When no strobe is low and step_n is high, mem_addr and beat_pos keep their values.
- R5: With order_xor = 0, the low two bits of mem_addr equal (start bits + beat_pos) mod 4. For example, a start value of 1 gives 1,2,3,0.
- R6: With order_xor = 1, the low two bits of mem_addr equal start bits XOR beat_pos. For example, a start value of 1 gives 1,0,3,2.
- R7: A strobe sampled low in the same cycle as step_n low starts a new burst: beat_pos becomes 0 and the address is reloaded, and no step is taken.
- R8: Between starts, the upper bits of mem_addr (bit 2 and above) keep the captured value, whatever req_addr does.
- R9: After four steps the sequence wraps: beat_pos returns to 0 and the low bits return to the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cpu_n | input | 1 | Active-low burst start from the processor |
| start_cache_n | input | 1 | Active-low burst start from the cache controller |
| step_n | input | 1 | Active-low step to the next beat |
| order_xor | input | 1 | Burst order select: 0 = linear, 1 = XOR-interleaved |
| req_addr | input | ADDR_W | External address, captured at a burst start |
| mem_addr | output | ADDR_W | Current burst address |
| beat_pos | output | BURST_BITS | Beat number within the current burst |

## Verification
Every result appears one edge after the input that causes it. A start or a step sampled at edge N is visible on mem_addr and beat_pos right after edge N, because the outputs are decoded from registers with no extra stage. The bench drives inputs on the falling edge and compares one time unit after the next rising edge, so each check sees exactly one edge's effect. Expected values come from an arithmetic model in the bench, which sweeps both orders, both strobes and all four start values.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic {
      ORDER_LINEAR = 1'b0,
      ORDER_XOR    = 1'b1
   } burst_order_e;

   localparam int DEF_ADDR_W     = 8;
   localparam int DEF_BURST_BITS = 2;
endpackage

// File: rtl/burst_addr_hold.sv
module burst_addr_hold #(
   parameter int ADDR_W     = 8,
   parameter int BURST_BITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        addr_in,
   output logic [ADDR_W-1:0]        addr_base
);
   localparam int UP_W = ADDR_W - BURST_BITS;

   generate
      if (UP_W < 1) begin : g_bad_width
         $error("burst_addr_hold: ADDR_W must exceed BURST_BITS");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_base <= '0;
      else if (load)
         addr_base <= addr_in;
   end

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_base[ADDR_W-1:BURST_BITS])); // R8
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  step,
   output logic [BURST_BITS-1:0] beat
);
   generate
      if (BURST_BITS < 1 || BURST_BITS > 8) begin : g_bad_bits
         $error("burst_beat_ctr: BURST_BITS out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat <= '0;
      else if (load)
         beat <= '0;
      else if (step)
         beat <= beat + 1'b1;
   end

   AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat == '0)); // R7

   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step) |=> (beat == $past(beat) + 1'b1)); // R4

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(beat)); // R4
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_pkg::*;
#(
   parameter int BURST_BITS = 2
) (
   input  logic [BURST_BITS-1:0] seed,
   input  logic [BURST_BITS-1:0] beat,
   input  burst_order_e          order,
   output logic [BURST_BITS-1:0] low_addr
);
   logic [BURST_BITS-1:0] lin_addr;
   logic [BURST_BITS-1:0] xor_addr;

   genvar gi;
   generate
      for (gi = 0; gi < BURST_BITS; gi++) begin : g_xor_bit
         assign xor_addr[gi] = seed[gi] ^ beat[gi];
      end
   endgenerate

   assign lin_addr = seed + beat;

   always_comb begin
      case (order)
         ORDER_XOR: low_addr = xor_addr;
         default:   low_addr = lin_addr;
      endcase
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W     = DEF_ADDR_W,
   parameter int BURST_BITS = DEF_BURST_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_cpu_n,
   input  logic                  start_cache_n,
   input  logic                  step_n,
   input  logic                  order_xor,
   input  logic [ADDR_W-1:0]     req_addr,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [BURST_BITS-1:0] beat_pos
);
   logic                  burst_load;
   logic                  burst_step;
   logic [ADDR_W-1:0]     addr_base;
   logic [BURST_BITS-1:0] low_addr;
   burst_order_e          order_sel;

   assign burst_load = !start_cpu_n || !start_cache_n;
   assign burst_step = !step_n;
   assign order_sel  = burst_order_e'(order_xor);

   burst_addr_hold #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (burst_load),
      .addr_in  (req_addr),
      .addr_base(addr_base)
   );

   burst_beat_ctr #(.BURST_BITS(BURST_BITS)) ctr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (burst_load),
      .step (burst_step),
      .beat (beat_pos)
   );

   burst_seq_map #(.BURST_BITS(BURST_BITS)) map_i (
      .seed    (addr_base[BURST_BITS-1:0]),
      .beat    (beat_pos),
      .order   (order_sel),
      .low_addr(low_addr)
   );

   assign mem_addr = {addr_base[ADDR_W-1:BURST_BITS], low_addr};

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      burst_load |=> (mem_addr == $past(req_addr) && beat_pos == '0)); // R2

   AST_CACHE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_cache_n && start_cpu_n) |=> (mem_addr == $past(req_addr))); // R3

   AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_load |=> $stable(mem_addr[ADDR_W-1:BURST_BITS])); // R8
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
   localparam int CLK_P = 10;
   localparam int AW    = 8;
   localparam int BB    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_cpu_n = 1'b1;
   logic          start_cache_n = 1'b1;
   logic          step_n = 1'b1;
   logic          order_xor = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [AW-1:0] mem_addr;
   logic [BB-1:0] beat_pos;

   int total = 0;
   int bad = 0;

   int exp_upper = 0;
   int exp_seed = 0;
   int exp_beat = 0;

   always #(CLK_P/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_cpu_n(start_cpu_n),
      .start_cache_n(start_cache_n), .step_n(step_n), .order_xor(order_xor),
      .req_addr(req_addr), .mem_addr(mem_addr), .beat_pos(beat_pos)
   );

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   function automatic int exp_addr();
      int lo;
      lo = order_xor ? (exp_seed ^ exp_beat) : ((exp_seed + exp_beat) % 4);
      return exp_upper * 4 + lo;
   endfunction

   // one cycle: drive at falling edge, check after the rising edge
   task automatic cyc(input bit cpu, input bit cache, input bit adv,
                      input int addr, input string req);
      @(negedge clk);
      start_cpu_n   = !cpu;
      start_cache_n = !cache;
      step_n        = !adv;
      req_addr      = AW'(addr);
      if (cpu || cache) begin
         exp_upper = addr / 4;
         exp_seed  = addr % 4;
         exp_beat  = 0;
      end else if (adv) begin
         exp_beat = (exp_beat + 1) % 4;
      end
      @(posedge clk);
      #1;
      chk({req, " addr"}, int'(mem_addr), exp_addr());
      chk({req, " beat"}, int'(beat_pos), exp_beat);
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset addr", int'(mem_addr), 0);
      chk("R1 reset beat", int'(beat_pos), 0);
      @(negedge clk);
      rst_n = 1'b1;
      req_addr = 8'hA5;
      @(posedge clk);
      #1;
      chk("R1 idle after reset", int'(mem_addr), 0);

      for (int m = 0; m < 2; m++) begin
         @(negedge clk);
         order_xor = m[0];
         for (int s = 0; s < 2; s++) begin
            for (int seed = 0; seed < 4; seed++) begin
               int base;
               base = ((seed * 37 + m * 11 + s * 5 + 3) % 64) * 4 + seed;
               if (s == 0) cyc(1'b1, 1'b0, 1'b0, base, "R2 cpu start");
               else        cyc(1'b0, 1'b1, 1'b0, base, "R3 cache start");
               cyc(1'b0, 1'b0, 1'b1, base ^ 8'hFC, m ? "R6 step" : "R5 step");
               cyc(1'b0, 1'b0, 1'b1, 8'h3C, m ? "R6 step" : "R5 step");
               cyc(1'b0, 1'b0, 1'b0, 8'hFF, "R4 hold");
               cyc(1'b0, 1'b0, 1'b0, 8'h00, "R8 upper held");
               cyc(1'b0, 1'b0, 1'b1, 8'h81, m ? "R6 step" : "R5 step");
               cyc(1'b0, 1'b0, 1'b1, 8'h42, "R9 wrap");
               chk("R9 wrap low bits", int'(mem_addr) % 4, seed);
               cyc(1'b0, 1'b0, 1'b1, 8'h17, "R9 after wrap");
               cyc(s == 0, s == 1, 1'b1, (base + 100) % 256, "R7 start beats step");
               cyc(1'b1, 1'b1, 1'b0, (base + 7) % 256, "R2 R3 both strobes");
            end
         end
      end

      @(negedge clk);
      order_xor = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, 8'h01, "R5 linear example");
      cyc(1'b0, 1'b0, 1'b1, 8'h00, "R5 linear example");
      chk("R5 linear 1->2", int'(mem_addr) % 4, 2);
      @(negedge clk);
      order_xor = 1'b1;
      cyc(1'b0, 1'b1, 1'b0, 8'h01, "R6 xor example");
      cyc(1'b0, 1'b0, 1'b1, 8'h00, "R6 xor example");
      chk("R6 xor 1->0", int'(mem_addr) % 4, 0);
      cyc(1'b0, 1'b0, 1'b1, 8'h00, "R6 xor example");
      chk("R6 xor ->3", int'(mem_addr) % 4, 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule